// File: doc/BRIEF.md
# Timer Interrupt Flag and Mask Unit

This block holds the interrupt status and enable state of an eight-channel timer. Four channels are output compares and three are input captures. One further channel acts as either a capture or a compare, chosen by a mode input. The block receives one-cycle event pulses: compare matches, and capture edges that have already been qualified by polarity. Each pulse latches a sticky flag.

Software reaches the flags and the enables through a byte-wide register port that holds two registers. A select input chooses between them. Flags are cleared by writing ones. A single active-high interrupt request is raised while any flag is set together with its enable bit.

Both registers share one bit layout. From bit 7 down to bit 0 the bits are: compare 1, compare 2, compare 3, compare 4, the shared capture-4/compare-5 channel, capture 1, capture 2, capture 3.

Top module: `tfm_irq_unit`

## Requirements
- R1: While `rst` is high at a clock edge, the flag register, the mask register and `irq_o` all go to zero.
- R2: A pulse on `cmp_match_i[k]` (k = 0..3, compare k+1) sets flag bit 7-k at the next edge. A pulse on `cap_edge_i[j]` (j = 0..2, capture j+1) sets flag bit 2-j at the next edge.
- R3: A write with `reg_sel_i` = 0 clears every flag bit where `wr_data_i` holds a one. Flag bits where `wr_data_i` holds a zero keep their value.
- R4: If a set event and a write-one clear reach the same flag bit in the same cycle, the flag ends up set.
- R5: Flags set on their events whatever the value of the mask register.
- R6: Flag bit 3 is set by `cap_edge_i[3]` when `shared_cap_mode_i` is 1, and by `cmp_match_i[4]` when it is 0. The pulse from the channel that is not selected has no effect.
- R7: `irq_o` is 1 exactly when some bit position holds a one in both the flag register and the mask register. It follows the registers with no added cycle.
- R8: A write with `reg_sel_i` = 1 loads `wr_data_i` into the mask register at the next edge. `rd_data_o` combinationally shows the flag register when `reg_sel_i` = 0 and the mask register when `reg_sel_i` = 1. Reading has no side effects.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_sel_i | input | 1 | Register select: 0 selects the flag register, 1 selects the mask register |
| wr_en_i | input | 1 | Write strobe for the selected register |
| wr_data_i | input | 8 | Write data |
| rd_data_o | output | 8 | Contents of the selected register |
| cmp_match_i | input | 5 | Compare match pulses; index 0 is compare 1 and index 4 is compare 5 |
| cap_edge_i | input | 4 | Qualified capture edge pulses; index 0 is capture 1 and index 3 is capture 4 |
| shared_cap_mode_i | input | 1 | Role of the shared channel: 1 selects capture 4, 0 selects compare 5 |
| irq_o | output | 1 | Interrupt request |

## Verification
A hardware event and a software write-one clear can land on the same flag bit in the same cycle. The bench provokes this by first setting every flag. It then issues clear writes for all 256 data values, and each write carries a varied pattern of compare and capture pulses in the same cycle. The result is judged against a model in which the event wins. The shared bit is also swept with both mode values, so that the selected pulse, the ignored pulse and a concurrent clear are all seen.

// File: rtl/tfm_pkg.sv
package tfm_pkg;
    localparam int REG_W      = 8;
    localparam int N_CMP      = 4;
    localparam int N_CAP      = 3;
    localparam int N_CMP_IN   = N_CMP + 1;
    localparam int N_CAP_IN   = N_CAP + 1;
    localparam int BIT_SHARED = REG_W - 1 - N_CMP;

    typedef enum logic {SEL_FLAG = 1'b0, SEL_MASK = 1'b1} tfm_sel_e;

    typedef struct packed {
        logic             en;
        tfm_sel_e         sel;
        logic [REG_W-1:0] data;
    } tfm_wr_t;

    function automatic int cmp_pos(input int k);
        return REG_W - 1 - k;
    endfunction

    function automatic int cap_pos(input int j);
        return BIT_SHARED - 1 - j;
    endfunction
endpackage

// File: rtl/tfm_evt_map.sv
module tfm_evt_map
    import tfm_pkg::*;
(
    input  logic [N_CMP_IN-1:0] cmp_match_i,
    input  logic [N_CAP_IN-1:0] cap_edge_i,
    input  logic                shared_cap_mode_i,
    output logic [REG_W-1:0]    set_o
);
    for (genvar k = 0; k < N_CMP; k++) begin : g_cmp
        assign set_o[cmp_pos(k)] = cmp_match_i[k];
    end
    for (genvar j = 0; j < N_CAP; j++) begin : g_cap
        assign set_o[cap_pos(j)] = cap_edge_i[j];
    end
    assign set_o[BIT_SHARED] = shared_cap_mode_i ? cap_edge_i[N_CAP_IN-1]
                                                 : cmp_match_i[N_CMP_IN-1];
endmodule

// File: rtl/tfm_flag_reg.sv
module tfm_flag_reg
    import tfm_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [REG_W-1:0] set_i,
    input  tfm_wr_t          wr_i,
    output logic [REG_W-1:0] flag_o
);
    logic [REG_W-1:0] clr;

    assign clr = (wr_i.en && wr_i.sel == SEL_FLAG) ? wr_i.data : '0;

    for (genvar i = 0; i < REG_W; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst)           flag_o[i] <= 1'b0;
            else if (set_i[i]) flag_o[i] <= 1'b1;
            else if (clr[i])   flag_o[i] <= 1'b0;
        end
    end
endmodule

// File: rtl/tfm_mask_reg.sv
module tfm_mask_reg
    import tfm_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  tfm_wr_t          wr_i,
    output logic [REG_W-1:0] mask_o
);
    always_ff @(posedge clk) begin
        if (rst)                                  mask_o <= '0;
        else if (wr_i.en && wr_i.sel == SEL_MASK) mask_o <= wr_i.data;
    end
endmodule

// File: rtl/tfm_irq_unit.sv
module tfm_irq_unit
    import tfm_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                reg_sel_i,
    input  logic                wr_en_i,
    input  logic [REG_W-1:0]    wr_data_i,
    output logic [REG_W-1:0]    rd_data_o,
    input  logic [N_CMP_IN-1:0] cmp_match_i,
    input  logic [N_CAP_IN-1:0] cap_edge_i,
    input  logic                shared_cap_mode_i,
    output logic                irq_o
);
    tfm_wr_t          wr;
    logic [REG_W-1:0] set_vec;
    logic [REG_W-1:0] flag_q;
    logic [REG_W-1:0] mask_q;

    assign wr.en   = wr_en_i;
    assign wr.sel  = tfm_sel_e'(reg_sel_i);
    assign wr.data = wr_data_i;

    tfm_evt_map u_map (
        .cmp_match_i       (cmp_match_i),
        .cap_edge_i        (cap_edge_i),
        .shared_cap_mode_i (shared_cap_mode_i),
        .set_o             (set_vec)
    );

    tfm_flag_reg u_flag (
        .clk    (clk),
        .rst    (rst),
        .set_i  (set_vec),
        .wr_i   (wr),
        .flag_o (flag_q)
    );

    tfm_mask_reg u_mask (
        .clk    (clk),
        .rst    (rst),
        .wr_i   (wr),
        .mask_o (mask_q)
    );

    assign rd_data_o = (wr.sel == SEL_MASK) ? mask_q : flag_q;
    assign irq_o     = |(flag_q & mask_q);
endmodule

// File: rtl/tfm_irq_unit_chk.sv
module tfm_irq_unit_chk
    import tfm_pkg::*;
(
    input logic                clk,
    input logic                rst,
    input logic                reg_sel_i,
    input logic                wr_en_i,
    input logic [REG_W-1:0]    wr_data_i,
    input logic [N_CMP_IN-1:0] cmp_match_i,
    input logic [N_CAP_IN-1:0] cap_edge_i,
    input logic                shared_cap_mode_i,
    input logic                irq_o,
    input logic [REG_W-1:0]    flag_q,
    input logic [REG_W-1:0]    mask_q
);
    AST_RESET_CLEAR: assert property (@(posedge clk) rst |=> (flag_q == '0 && mask_q == '0)); // R1
    AST_CMP1_SETS: assert property (@(posedge clk) disable iff (rst) cmp_match_i[0] |=> flag_q[7]); // R2
    AST_CAP3_SETS: assert property (@(posedge clk) disable iff (rst) cap_edge_i[2] |=> flag_q[0]); // R2
    AST_CLEAR_ONES: assert property (@(posedge clk) disable iff (rst)
        (wr_en_i && !reg_sel_i && cmp_match_i == '0 && cap_edge_i == '0)
        |=> flag_q == ($past(flag_q) & ~$past(wr_data_i))); // R3
    AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (wr_en_i && !reg_sel_i && wr_data_i[5] && cmp_match_i[2]) |=> flag_q[5]); // R4
    AST_SHARED_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (!shared_cap_mode_i && cap_edge_i[3] && !cmp_match_i[4] && !flag_q[3]) |=> !flag_q[3]); // R6
    AST_SHARED_CAP: assert property (@(posedge clk) disable iff (rst)
        (shared_cap_mode_i && cap_edge_i[3]) |=> flag_q[3]); // R6
    AST_NO_MASK_NO_IRQ: assert property (@(posedge clk) disable iff (rst) (mask_q == '0) |-> !irq_o); // R7
    AST_MASK_LOAD: assert property (@(posedge clk) disable iff (rst)
        (wr_en_i && reg_sel_i) |=> mask_q == $past(wr_data_i)); // R8
    AST_MASK_HOLD: assert property (@(posedge clk) disable iff (rst)
        !(wr_en_i && reg_sel_i) |=> $stable(mask_q)); // R8
endmodule

bind tfm_irq_unit tfm_irq_unit_chk u_chk (
    .clk               (clk),
    .rst               (rst),
    .reg_sel_i         (reg_sel_i),
    .wr_en_i           (wr_en_i),
    .wr_data_i         (wr_data_i),
    .cmp_match_i       (cmp_match_i),
    .cap_edge_i        (cap_edge_i),
    .shared_cap_mode_i (shared_cap_mode_i),
    .irq_o             (irq_o),
    .flag_q            (flag_q),
    .mask_q            (mask_q)
);

// File: tb/tfm_irq_unit_tb.sv
module tfm_irq_unit_tb;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       reg_sel_i = 1'b0;
    logic       wr_en_i = 1'b0;
    logic [7:0] wr_data_i = '0;
    logic [7:0] rd_data_o;
    logic [4:0] cmp_match_i = '0;
    logic [3:0] cap_edge_i = '0;
    logic       shared_cap_mode_i = 1'b0;
    logic       irq_o;

    int   n_tests = 0;
    int   n_fail  = 0;
    bit   done    = 1'b0;
    logic [7:0] exp_flag = '0;
    logic [7:0] exp_mask = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tfm_irq_unit u_dut (
        .clk (clk), .rst (rst), .reg_sel_i (reg_sel_i), .wr_en_i (wr_en_i),
        .wr_data_i (wr_data_i), .rd_data_o (rd_data_o), .cmp_match_i (cmp_match_i),
        .cap_edge_i (cap_edge_i), .shared_cap_mode_i (shared_cap_mode_i), .irq_o (irq_o)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    task automatic check_all(input string tag);
        reg_sel_i = 1'b0; #1;
        check(tag, rd_data_o, exp_flag);
        reg_sel_i = 1'b1; #1;
        check(tag, rd_data_o, exp_mask);
        check({tag, "/R7"}, {7'd0, irq_o}, {7'd0, |(exp_flag & exp_mask)});
    endtask

    // one clock of stimulus, model update from the requirements, then checks
    task automatic step(input string tag, input logic [4:0] cm, input logic [3:0] ce,
                        input logic mode, input logic wr, input logic sel,
                        input logic [7:0] wd);
        logic [7:0] setv;
        @(negedge clk);
        cmp_match_i = cm; cap_edge_i = ce; shared_cap_mode_i = mode;
        wr_en_i = wr; reg_sel_i = sel; wr_data_i = wd;
        setv = {cm[0], cm[1], cm[2], cm[3], (mode ? ce[3] : cm[4]), ce[0], ce[1], ce[2]};
        @(posedge clk);
        if (wr && !sel) exp_flag = (exp_flag & ~wd) | setv;
        else            exp_flag = exp_flag | setv;
        if (wr && sel)  exp_mask = wd;
        #1;
        cmp_match_i = '0; cap_edge_i = '0; wr_en_i = 1'b0;
        check_all(tag);
    endtask

    // place flag pattern f through events only (flags assumed clear)
    task automatic set_by_events(input string tag, input logic [7:0] f);
        step(tag, {1'b0, f[4], f[5], f[6], f[7]}, {f[3], f[0], f[1], f[2]}, 1'b1, 1'b0, 1'b0, 8'h00);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        cmp_match_i = 5'h1F; cap_edge_i = 4'hF; wr_en_i = 1'b1; reg_sel_i = 1'b1; wr_data_i = 8'hFF;
        @(posedge clk); #1;
        cmp_match_i = '0; cap_edge_i = '0; wr_en_i = 1'b0;
        check_all("R1 reset");
        @(negedge clk); rst = 1'b0;

        // R2 R5 R6: every event combination, both modes, mask held at zero
        for (int mode = 0; mode < 2; mode++) begin
            for (int p = 0; p < 512; p++) begin
                step("R3 clear-all", '0, '0, mode[0], 1'b1, 1'b0, 8'hFF);
                step("R2/R5/R6 events", p[4:0], p[8:5], mode[0], 1'b0, 1'b0, 8'h00);
            end
        end

        // R6 directed: unselected source ignored in each mode
        step("R3 clear-all", '0, '0, 1'b0, 1'b1, 1'b0, 8'hFF);
        step("R6 cap4 ignored", '0, 4'h8, 1'b0, 1'b0, 1'b0, 8'h00);
        check("R6 bit3 low", {7'd0, exp_flag[3]}, 8'h00);
        step("R6 cmp5 ignored", 5'h10, '0, 1'b1, 1'b0, 1'b0, 8'h00);
        check("R6 bit3 still low", {7'd0, exp_flag[3]}, 8'h00);

        // R3 R4: all clear patterns, concurrent events in the same cycle
        for (int i = 0; i < 256; i++) begin
            step("R2 fill", 5'h1F, 4'hF, 1'b1, 1'b0, 1'b0, 8'h00);
            step("R3/R4 clear+set", 5'((i * 29) >> 3), 4'((i * 7) >> 2),
                 i[0], 1'b1, 1'b0, i[7:0]);
            step("R3 write zero keeps", '0, '0, i[0], 1'b1, 1'b0, 8'h00);
        end

        // R7 R8: all mask values against several flag patterns
        for (int m = 0; m < 256; m++) begin
            for (int q = 0; q < 3; q++) begin
                step("R3 clear-all", '0, '0, 1'b1, 1'b1, 1'b0, 8'hFF);
                set_by_events("R2 pattern", 8'((m * 73 + q * 91 + 11) & 255));
                step("R8 mask write", '0, '0, 1'b1, 1'b1, 1'b1, m[7:0]);
            end
        end

        // R8: repeated reads leave both registers unchanged
        step("R8 mask 5A", '0, '0, 1'b1, 1'b1, 1'b1, 8'h5A);
        step("R8 read only", '0, '0, 1'b1, 1'b0, 1'b0, 8'h00);
        check_all("R8 reread");

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule